// File: doc/BRIEF.md
# Clock-Enable Power-Down Sequencer

This controller sits beside a registered command/address buffer. It takes the block into and out of a power-down mode in which input termination is off. It watches the latched clock-enable inputs and, once every one of them has been sampled low, it shuts the buffer down in stages. The registered clock-enable and on-die-termination outputs drop low at once. The address/command input receivers switch off a set number of cycles later. The parity receiver follows one cycle after that, so that a half-disabled input pair cannot raise a false parity error. The remaining outputs go to high impedance after their own delay, counted from the moment the clock-enable outputs went low.

When any clock-enable input comes back high during power-down, every buffer is switched on again. The clock-enable outputs resume following their inputs after a set wake-up delay. The chip-select outputs are held high until the first normal cycle has passed, so no command can be decoded while the wake-up is in progress. When the block runs with only two chip selects, both of them low at a power-down transition would open a control-word access. That case is flagged on a registered error output.

Top module: `cke_pd_sequencer`

## Requirements
- R1: A synchronous active-low reset returns the block to normal operation. In that state `cmdInBufEn`, `parInBufEn` and `outDrvEn` are 1 and `csErr` is 0, including when reset arrives during power-down.
- R2: In normal operation `ckeOut` equals `ckeIn`, `odtOut` equals `odtIn` and `csOut` equals `csIn`. Power-down entry does not start while at least one `ckeIn` bit is 1.
- R3: At the rising edge that samples `ckeIn` all zero in normal operation (edge E), `ckeOut` and `odtOut` become all zero. They stay zero until the exit sequence ends.
- R4: `cmdInBufEn` is 1 for the first IN_DIS_CYC cycles after edge E and 0 from edge E+IN_DIS_CYC onward.
- R5: `parInBufEn` goes to 0 exactly one cycle after `cmdInBufEn` goes to 0, never earlier.
- R6: `outDrvEn` goes to 0 at edge E+Q_DIS_CYC. This delay is counted independently of R4.
- R7: Once entry has started, a `ckeIn` returning high is ignored until power-down is reached. The outputs of R3 to R5 keep their entry timing, and the exit starts only at the edge after power-down is reached.
- R8: In power-down, the edge that samples any `ckeIn` bit at 1 (edge X) sets `cmdInBufEn`, `parInBufEn` and `outDrvEn` to 1. `ckeOut` stays zero until edge X+EN_CYC and then follows `ckeIn`.
- R9: From edge X until one cycle after `ckeOut` resumes, `csOut` is all ones, whatever `csIn` is. After that it follows `csIn`.
- R10: `csErr` is 1 in the cycle after an edge that samples `quadCsEn`=0 and `csIn[1:0]`=00 while that edge starts entry, starts exit, or falls inside the exit sequence. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| quadCsEn | input | 1 | 1 when four chip selects are in use |
| ckeIn | input | NUM_CKE | Latched clock-enable inputs |
| odtIn | input | NUM_CKE | Latched termination-control inputs |
| csIn | input | NUM_CS | Latched chip-select inputs, active low |
| ckeOut | output | NUM_CKE | Registered clock-enable outputs |
| odtOut | output | NUM_CKE | Registered termination-control outputs |
| csOut | output | NUM_CS | Registered chip-select outputs |
| cmdInBufEn | output | 1 | Address/command input receiver enable |
| parInBufEn | output | 1 | Parity input receiver enable |
| outDrvEn | output | 1 | Drive enable for address/command/chip-select outputs, 0 = high impedance |
| csErr | output | 1 | Illegal chip-select pattern at a power-down transition |

## Verification
Clock-enable patterns with only one bit low must leave the block in normal operation. Only the all-low pattern may start entry, which separates an AND of the lanes from an OR. A full entry is stepped cycle by cycle, with input and output delays of different lengths, so that a wrong counter load, a swapped ordering between the parity and command receivers, or a tri-state tied to the wrong counter each shows up in a distinct cycle. A clock-enable that rises during entry checks that the entry finishes before the exit begins. Chip-select patterns with both low bits cleared are applied under both chip-select modes, both inside and outside the transition window, to tell the error flag apart from a plain decode of the inputs.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;

  typedef enum logic [1:0] {
    PD_NORMAL   = 2'd0,
    PD_ENTERING = 2'd1,
    PD_DOWN     = 2'd2,
    PD_EXITING  = 2'd3
  } pdState_e;

  // strobes from the controller to the output path
  typedef struct packed {
    logic passCmd;      // outputs follow inputs
    logic forceCsHigh;  // chip selects held inactive
    logic inBufEn;      // address/command receivers on
    logic parBufEn;     // parity receiver on
    logic outDrvEn;     // output drivers on
  } pdStrobe_t;

endpackage

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
  import cke_pd_pkg::*;
#(
  parameter int NUM_CKE    = 2,
  parameter int IN_DIS_CYC = 4,
  parameter int Q_DIS_CYC  = 6,
  parameter int EN_CYC     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               quadCsEn,
  input  logic [NUM_CKE-1:0] ckeIn,
  input  logic [1:0]         csLow,
  output pdStrobe_t          strobe,
  output logic               csErr
);

  localparam int MAX_A   = (IN_DIS_CYC > Q_DIS_CYC) ? IN_DIS_CYC : Q_DIS_CYC;
  localparam int MAX_CYC = (MAX_A > EN_CYC) ? MAX_A : EN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  pdState_e         state;
  logic [CNT_W-1:0] inDisCnt;
  logic [CNT_W-1:0] qDisCnt;
  logic [CNT_W-1:0] enCnt;
  logic             csHold;

  logic allCkeLow;
  logic anyCkeHigh;
  logic startEntry;
  logic startExit;
  logic csIllegal;
  logic errWindow;

  assign allCkeLow  = (ckeIn == '0);
  assign anyCkeHigh = |ckeIn;
  assign startEntry = (state == PD_NORMAL) && allCkeLow;
  assign startExit  = (state == PD_DOWN) && anyCkeHigh;
  assign csIllegal  = !quadCsEn && (csLow == 2'b00);
  assign errWindow  = startEntry || startExit || (state == PD_EXITING);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PD_NORMAL;
      inDisCnt <= '0;
      qDisCnt  <= '0;
      enCnt    <= '0;
      csHold   <= 1'b0;
      csErr    <= 1'b0;
    end else begin
      csErr <= csIllegal && errWindow;
      unique case (state)
        PD_NORMAL: begin
          csHold <= 1'b0;
          if (allCkeLow) begin
            state    <= PD_ENTERING;
            inDisCnt <= CNT_W'(IN_DIS_CYC);
            qDisCnt  <= CNT_W'(Q_DIS_CYC);
          end
        end
        PD_ENTERING: begin
          if (qDisCnt != '0) qDisCnt <= qDisCnt - 1'b1;
          if (inDisCnt != '0) inDisCnt <= inDisCnt - 1'b1;
          else                state    <= PD_DOWN;
        end
        PD_DOWN: begin
          if (anyCkeHigh) begin
            state   <= PD_EXITING;
            enCnt   <= CNT_W'(EN_CYC - 1);
            qDisCnt <= '0;
          end else if (qDisCnt != '0) begin
            qDisCnt <= qDisCnt - 1'b1;
          end
        end
        PD_EXITING: begin
          if (enCnt != '0) enCnt <= enCnt - 1'b1;
          else begin
            state  <= PD_NORMAL;
            csHold <= 1'b1;
          end
        end
        default: state <= PD_NORMAL;
      endcase
    end
  end

  logic powering;
  assign powering = (state == PD_ENTERING) || (state == PD_DOWN);

  always_comb begin
    strobe.passCmd     = (state == PD_NORMAL);
    strobe.forceCsHigh = !((state == PD_NORMAL) && !csHold);
    strobe.inBufEn     = !((state == PD_DOWN) ||
                           ((state == PD_ENTERING) && (inDisCnt == '0)));
    strobe.parBufEn    = (state != PD_DOWN);
    strobe.outDrvEn    = !(powering && (qDisCnt == '0));
  end

endmodule

// File: rtl/cke_pd_outpath.sv
module cke_pd_outpath
  import cke_pd_pkg::*;
#(
  parameter int NUM_CKE = 2,
  parameter int NUM_CS  = 4
) (
  input  pdStrobe_t          strobe,
  input  logic [NUM_CKE-1:0] ckeIn,
  input  logic [NUM_CKE-1:0] odtIn,
  input  logic [NUM_CS-1:0]  csIn,
  output logic [NUM_CKE-1:0] ckeOut,
  output logic [NUM_CKE-1:0] odtOut,
  output logic [NUM_CS-1:0]  csOut,
  output logic               cmdInBufEn,
  output logic               parInBufEn,
  output logic               outDrvEn
);

  // per-rank lanes: clock enable and termination are forced low off-normal
  for (genvar i = 0; i < NUM_CKE; i++) begin : g_rank
    assign ckeOut[i] = strobe.passCmd & ckeIn[i];
    assign odtOut[i] = strobe.passCmd & odtIn[i];
  end

  // chip-select lanes: active low, so forcing means driving 1
  for (genvar j = 0; j < NUM_CS; j++) begin : g_cs
    assign csOut[j] = strobe.forceCsHigh | csIn[j];
  end

  assign cmdInBufEn = strobe.inBufEn;
  assign parInBufEn = strobe.parBufEn;
  assign outDrvEn   = strobe.outDrvEn;

endmodule

// File: rtl/cke_pd_sequencer.sv
module cke_pd_sequencer
  import cke_pd_pkg::*;
#(
  parameter int NUM_CKE    = 2,
  parameter int NUM_CS     = 4,
  parameter int IN_DIS_CYC = 4,
  parameter int Q_DIS_CYC  = 6,
  parameter int EN_CYC     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               quadCsEn,
  input  logic [NUM_CKE-1:0] ckeIn,
  input  logic [NUM_CKE-1:0] odtIn,
  input  logic [NUM_CS-1:0]  csIn,
  output logic [NUM_CKE-1:0] ckeOut,
  output logic [NUM_CKE-1:0] odtOut,
  output logic [NUM_CS-1:0]  csOut,
  output logic               cmdInBufEn,
  output logic               parInBufEn,
  output logic               outDrvEn,
  output logic               csErr
);

  pdStrobe_t strobe;

  cke_pd_ctrl #(
    .NUM_CKE    (NUM_CKE),
    .IN_DIS_CYC (IN_DIS_CYC),
    .Q_DIS_CYC  (Q_DIS_CYC),
    .EN_CYC     (EN_CYC)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .quadCsEn (quadCsEn),
    .ckeIn    (ckeIn),
    .csLow    (csIn[1:0]),
    .strobe   (strobe),
    .csErr    (csErr)
  );

  cke_pd_outpath #(
    .NUM_CKE (NUM_CKE),
    .NUM_CS  (NUM_CS)
  ) path_i (
    .strobe     (strobe),
    .ckeIn      (ckeIn),
    .odtIn      (odtIn),
    .csIn       (csIn),
    .ckeOut     (ckeOut),
    .odtOut     (odtOut),
    .csOut      (csOut),
    .cmdInBufEn (cmdInBufEn),
    .parInBufEn (parInBufEn),
    .outDrvEn   (outDrvEn)
  );

endmodule

// File: rtl/cke_pd_chk.sv
module cke_pd_chk #(
  parameter int NUM_CKE = 2,
  parameter int NUM_CS  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               quadCsEn,
  input logic [NUM_CS-1:0]  csIn,
  input logic [NUM_CKE-1:0] ckeOut,
  input logic [NUM_CKE-1:0] odtOut,
  input logic [NUM_CS-1:0]  csOut,
  input logic               cmdInBufEn,
  input logic               parInBufEn,
  input logic               outDrvEn,
  input logic               csErr
);

  a_r1_reset_enables: assert property (@(posedge clk)
    !rstN |=> (cmdInBufEn && parInBufEn && outDrvEn && !csErr));

  a_r3_gated_outputs_low: assert property (@(posedge clk) disable iff (!rstN)
    !cmdInBufEn |-> (ckeOut == '0 && odtOut == '0));

  a_r5_parity_follows: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdInBufEn) |=> $fell(parInBufEn));

  a_r5_parity_not_first: assert property (@(posedge clk) disable iff (!rstN)
    !parInBufEn |-> !cmdInBufEn);

  a_r6_hiz_after_cke_low: assert property (@(posedge clk) disable iff (!rstN)
    !outDrvEn |-> (ckeOut == '0));

  a_r9_cs_held_on_wake: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmdInBufEn) && $past(rstN)) |-> (&csOut));

  a_r10_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    csErr |-> $past(!quadCsEn && csIn[1:0] == 2'b00));

endmodule

bind cke_pd_sequencer cke_pd_chk #(
  .NUM_CKE (NUM_CKE),
  .NUM_CS  (NUM_CS)
) chk_i (.*);

// File: tb/cke_pd_sequencer_tb.sv
module cke_pd_sequencer_tb_top;

  localparam int NCKE = 2;
  localparam int NCS  = 4;
  localparam int TIND = 4;
  localparam int TQD  = 6;
  localparam int TEN  = 3;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            quadCsEn = 1'b1;
  logic [NCKE-1:0] ckeIn = '1;
  logic [NCKE-1:0] odtIn = '0;
  logic [NCS-1:0]  csIn = '1;
  logic [NCKE-1:0] ckeOut;
  logic [NCKE-1:0] odtOut;
  logic [NCS-1:0]  csOut;
  logic            cmdInBufEn;
  logic            parInBufEn;
  logic            outDrvEn;
  logic            csErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cke_pd_sequencer #(
    .NUM_CKE (NCKE), .NUM_CS (NCS),
    .IN_DIS_CYC (TIND), .Q_DIS_CYC (TQD), .EN_CYC (TEN)
  ) dut_i (
    .clk (clk), .rstN (rstN), .quadCsEn (quadCsEn),
    .ckeIn (ckeIn), .odtIn (odtIn), .csIn (csIn),
    .ckeOut (ckeOut), .odtOut (odtOut), .csOut (csOut),
    .cmdInBufEn (cmdInBufEn), .parInBufEn (parInBufEn),
    .outDrvEn (outDrvEn), .csErr (csErr)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic goDown();
    ckeIn = '0;
    repeat (TIND + 2) tick();
  endtask

  task automatic tReset();
    rstN = 1'b0; ckeIn = 2'b11; odtIn = 2'b10; csIn = 4'b1001;
    tick(); tick();
    check("R1 inBuf", cmdInBufEn, 1); check("R1 par", parInBufEn, 1);
    check("R1 drv", outDrvEn, 1);     check("R1 err", csErr, 0);
    check("R1 cke", ckeOut, 2'b11);
    rstN = 1'b1; tick();
  endtask

  task automatic tNormal();
    ckeIn = 2'b10; odtIn = 2'b01; csIn = 4'b0110; tick(); tick();
    check("R2 cke", ckeOut, 2'b10); check("R2 odt", odtOut, 2'b01);
    check("R2 cs", csOut, 4'b0110); check("R2 noentry", cmdInBufEn, 1);
    ckeIn = 2'b01; odtIn = 2'b10; csIn = 4'b1011; tick(); tick();
    check("R2 cke2", ckeOut, 2'b01); check("R2 odt2", odtOut, 2'b10);
    check("R2 cs2", csOut, 4'b1011); check("R2 noentry2", outDrvEn, 1);
  endtask

  task automatic tEntry();
    odtIn = 2'b11; csIn = 4'b1010; ckeIn = 2'b00;
    tick();  // edge E
    for (int k = 0; k < 9; k++) begin
      check("R3 cke", ckeOut, 0); check("R3 odt", odtOut, 0);
      check("R4 inBuf", cmdInBufEn, (k < TIND) ? 1 : 0);
      check("R5 par", parInBufEn, (k < TIND + 1) ? 1 : 0);
      check("R6 drv", outDrvEn, (k < TQD) ? 1 : 0);
      tick();
    end
  endtask

  task automatic tExit();
    ckeIn = 2'b01; csIn = 4'b0101;
    tick();  // edge X
    for (int k = 0; k < 6; k++) begin
      check("R8 inBuf", cmdInBufEn, 1); check("R8 par", parInBufEn, 1);
      check("R8 drv", outDrvEn, 1);
      check("R8 cke", ckeOut, (k >= TEN) ? 2'b01 : 2'b00);
      check("R9 cs", csOut, (k <= TEN) ? 4'hF : 4'h5);
      tick();
    end
  endtask

  task automatic tIgnore();
    ckeIn = 2'b11; tick();
    ckeIn = 2'b00; tick();  // edge E
    ckeIn = 2'b11;
    for (int k = 0; k <= TIND; k++) begin
      check("R7 cke", ckeOut, 0);
      check("R7 inBuf", cmdInBufEn, (k < TIND) ? 1 : 0);
      tick();
    end
    check("R7 down", cmdInBufEn, 0);
    check("R7 par", parInBufEn, 0);
    tick();
    check("R7 wake", cmdInBufEn, 1);
    repeat (TEN + 1) tick();
    check("R7 normal", ckeOut, 2'b11);
  endtask

  task automatic tCsErr();
    quadCsEn = 1'b0; ckeIn = 2'b11; csIn = 4'b1100; tick();
    check("R10 normal", csErr, 0);
    ckeIn = 2'b00; tick();
    check("R10 entry", csErr, 1);
    tick();
    check("R10 entering", csErr, 0);
    repeat (TIND + 2) tick();
    check("R10 down", csErr, 0);
    ckeIn = 2'b10; tick();
    check("R10 exit", csErr, 1);
    quadCsEn = 1'b1; tick();
    check("R10 quad", csErr, 0);
    repeat (TEN + 2) tick();
    quadCsEn = 1'b1; ckeIn = 2'b00; tick();
    check("R10 quad entry", csErr, 0);
    repeat (TIND + 2) tick();
    check("R10 down2", cmdInBufEn, 0);
    rstN = 1'b0; tick();
    check("R1 midreset", cmdInBufEn, 1);
    check("R1 midreset drv", outDrvEn, 1);
    rstN = 1'b1; ckeIn = 2'b11; tick();
  endtask

  initial begin
    #1;
    tReset();
    tNormal();
    tEntry();
    tExit();
    tIgnore();
    ckeIn = 2'b11; tick();
    goDown();
    check("R4 down again", cmdInBufEn, 0);
    ckeIn = 2'b11; repeat (TEN + 2) tick();
    tCsErr();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule